// File: doc/BRIEF.md
# Remote Core Reset and Boot Controller

This block lets a local processor put a second processor into reset, keep it there as long as it wishes, and let it run again with a chosen start-up mode. The local side writes three control values in one write: a reset request bit, a hold bit and a two-bit start-up mode. The far core can refuse a reset by raising a mask line. That line may come from another clock domain, so it passes through a synchronizer first. The block drives a reset line and a start-up mode bus into the far core.

Two sticky event flags tell the local side what happened. One is raised when the far core actually goes into reset. The other is raised when it comes back out. Each flag is cleared by writing 1 to its position, and each one also appears on its own interrupt line. After the reset line rises, it always stays high for a minimum number of cycles, whatever software writes in the meantime.

Top module: `remote_core_boot_ctl`

## Requirements
- R1: While `rst` is high, and right after it falls, `remote_rst`, `remote_boot`, both flags and both interrupt lines are 0.
- R2: A control write with the request bit set, sampled at edge k while the synchronized mask is low, raises `remote_rst` after edge k+1 and not earlier.
- R3: While the synchronized mask is high, a set request bit does not raise `remote_rst`. The mask is `SYNC_STAGES` flops deep (default 2). Once the mask drops, a request that is still set takes effect.
- R4: Once high, `remote_rst` stays high for at least `MIN_HOLD` cycles (default 4), even if the request is cleared at once.
- R5: While the hold bit is set, `remote_rst` stays high, and `remote_boot` keeps its old value.
- R6: When the minimum time has passed and both the request bit and the hold bit are clear, `remote_rst` falls. On that same edge, `remote_boot` takes the stored mode field. At no other time does `remote_boot` change.
- R7: The entered-reset flag is set on the same edge that raises `remote_rst`.
- R8: The left-reset flag is set on the same edge that lowers `remote_rst`.
- R9: A clear write with `clr_sel[0]`=1 clears the entered-reset flag, and `clr_sel[1]`=1 clears the left-reset flag. Writing a 0 bit has no effect. If a flag is set and cleared on the same edge, the set wins.
- R10: `irq_enter` always equals the entered-reset flag, and `irq_leave` always equals the left-reset flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control fields |
| cfg_hr | input | 1 | Reset request bit |
| cfg_hold | input | 1 | Keep-in-reset bit |
| cfg_boot | input | BOOT_W | Start-up mode to apply at release |
| clr_we | input | 1 | Write strobe for flag clearing |
| clr_sel | input | 2 | Write-1-to-clear bits: [0] entered, [1] left |
| remote_mask | input | 1 | Far side refuses resets (asynchronous) |
| remote_rst | output | 1 | Reset line into the far core |
| remote_boot | output | BOOT_W | Start-up mode into the far core |
| pend_enter | output | 1 | Sticky flag: far core entered reset |
| pend_leave | output | 1 | Sticky flag: far core left reset |
| irq_enter | output | 1 | Interrupt for the entered-reset flag |
| irq_leave | output | 1 | Interrupt for the left-reset flag |

## Verification
The hardest case to reach is a flag clear that arrives on exactly the edge where the same flag is set. The bench counts cycles from the request write through the two-register path, and times a clear write to land on the edge that raises `remote_rst`. A second hard case is a request that was refused by the mask and then proceeds on its own once the mask drops. To reach it, the stimulus raises the mask, waits for the synchronizer to fill, and writes the request. It then drops the mask and expects the reset one cycle after the synchronized mask falls.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_MIN  = 2'd1,
    SEQ_HELD = 2'd2
  } seq_state_e;

  localparam int PEND_N     = 2;
  localparam int PEND_ENTER = 0;
  localparam int PEND_LEAVE = 1;
endpackage

// File: rtl/rcb_mask_sync.sv
module rcb_mask_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_out = async_in;
    end else begin : g_chain
      logic [STAGES-1:0] ff;
      for (genvar i = 0; i < STAGES; i++) begin : g_st
        if (i == 0) begin : g_first
          always_ff @(posedge clk) begin
            if (rst) ff[i] <= 1'b0;
            else     ff[i] <= async_in;
          end
        end else begin : g_next
          always_ff @(posedge clk) begin
            if (rst) ff[i] <= 1'b0;
            else     ff[i] <= ff[i-1];
          end
        end
      end
      assign sync_out = ff[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rcb_cfg_regs.sv
module rcb_cfg_regs #(
  parameter int BOOT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              hr_in,
  input  logic              hold_in,
  input  logic [BOOT_W-1:0] boot_in,
  output logic              hr_q,
  output logic              hold_q,
  output logic [BOOT_W-1:0] boot_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hr_q   <= 1'b0;
      hold_q <= 1'b0;
      boot_q <= '0;
    end else if (we) begin
      hr_q   <= hr_in;
      hold_q <= hold_in;
      boot_q <= boot_in;
    end
  end
endmodule

// File: rtl/rcb_seq.sv
module rcb_seq
  import rcb_pkg::*;
#(
  parameter int BOOT_W   = 2,
  parameter int MIN_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_hr,
  input  logic              req_hold,
  input  logic [BOOT_W-1:0] boot_sel,
  input  logic              mask_s,
  output logic              rst_o,
  output logic [BOOT_W-1:0] boot_o,
  output logic              enter_evt,
  output logic              leave_evt
);
  localparam int HOLD_C = (MIN_HOLD < 1) ? 1 : MIN_HOLD;
  localparam int CNT_W  = (HOLD_C < 2) ? 1 : $clog2(HOLD_C);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_C - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             min_done, release_ok;

  assign release_ok = !req_hr && !req_hold;
  assign min_done   = (state_q == SEQ_HELD) || (cnt_q == CNT_LAST);
  assign enter_evt  = (state_q == SEQ_RUN) && req_hr && !mask_s;
  assign leave_evt  = (state_q != SEQ_RUN) && min_done && release_ok;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_RUN:  if (enter_evt) state_d = SEQ_MIN;
      SEQ_MIN:  if (leave_evt) state_d = SEQ_RUN;
                else if (min_done) state_d = SEQ_HELD;
      SEQ_HELD: if (leave_evt) state_d = SEQ_RUN;
      default:  state_d = SEQ_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_RUN;
      cnt_q   <= '0;
      rst_o   <= 1'b0;
      boot_o  <= '0;
    end else begin
      state_q <= state_d;
      rst_o   <= (state_d != SEQ_RUN);
      if (enter_evt)                        cnt_q <= '0;
      else if (state_q == SEQ_MIN && !min_done) cnt_q <= cnt_q + 1'b1;
      if (leave_evt) boot_o <= boot_sel;
    end
  end
endmodule

// File: rtl/rcb_pend.sv
module rcb_pend #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic         clr_we,
  input  logic [N-1:0] clr_sel,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             pend[i] <= 1'b0;
      else if (set_evt[i]) pend[i] <= 1'b1;
      else if (clr_we && clr_sel[i]) pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/remote_core_boot_ctl.sv
module remote_core_boot_ctl
  import rcb_pkg::*;
#(
  parameter int BOOT_W      = 2,
  parameter int MIN_HOLD    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_hr,
  input  logic              cfg_hold,
  input  logic [BOOT_W-1:0] cfg_boot,
  input  logic              clr_we,
  input  logic [1:0]        clr_sel,
  input  logic              remote_mask,
  output logic              remote_rst,
  output logic [BOOT_W-1:0] remote_boot,
  output logic              pend_enter,
  output logic              pend_leave,
  output logic              irq_enter,
  output logic              irq_leave
);
  logic              mask_sync;
  logic              hr_q, hold_q;
  logic [BOOT_W-1:0] boot_q;
  logic              enter_evt, leave_evt;
  logic [PEND_N-1:0] set_vec, pend_vec;

  rcb_mask_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(remote_mask), .sync_out(mask_sync)
  );

  rcb_cfg_regs #(.BOOT_W(BOOT_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .hr_in(cfg_hr), .hold_in(cfg_hold),
    .boot_in(cfg_boot), .hr_q(hr_q), .hold_q(hold_q), .boot_q(boot_q)
  );

  rcb_seq #(.BOOT_W(BOOT_W), .MIN_HOLD(MIN_HOLD)) u_seq (
    .clk(clk), .rst(rst), .req_hr(hr_q), .req_hold(hold_q), .boot_sel(boot_q),
    .mask_s(mask_sync), .rst_o(remote_rst), .boot_o(remote_boot),
    .enter_evt(enter_evt), .leave_evt(leave_evt)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[PEND_ENTER] = enter_evt;
    set_vec[PEND_LEAVE] = leave_evt;
  end

  rcb_pend #(.N(PEND_N)) u_pend (
    .clk(clk), .rst(rst), .set_evt(set_vec), .clr_we(clr_we),
    .clr_sel(clr_sel), .pend(pend_vec)
  );

  assign pend_enter = pend_vec[PEND_ENTER];
  assign pend_leave = pend_vec[PEND_LEAVE];
  assign irq_enter  = pend_vec[PEND_ENTER];
  assign irq_leave  = pend_vec[PEND_LEAVE];
endmodule

// File: rtl/rcb_chk.sv
module rcb_chk #(
  parameter int BOOT_W   = 2,
  parameter int MIN_HOLD = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              remote_rst,
  input logic [BOOT_W-1:0] remote_boot,
  input logic              pend_enter,
  input logic              pend_leave,
  input logic              mask_s,
  input logic              hold_q,
  input logic              clr_we,
  input logic [1:0]        clr_sel
);
  localparam int HW = $clog2(MIN_HOLD + 1) + 1;
  localparam logic [HW-1:0] HI_SAT = HW'(MIN_HOLD);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !remote_rst) hi_cnt <= '0;
    else if (hi_cnt != HI_SAT) hi_cnt <= hi_cnt + 1'b1;
  end

  // R4
  min_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(remote_rst) |-> hi_cnt >= HI_SAT);
  // R7
  enter_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(remote_rst) |-> pend_enter);
  // R8
  leave_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(remote_rst) |-> pend_leave);
  // R6
  boot_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(remote_rst) |-> $stable(remote_boot));
  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (remote_rst && hold_q) |=> remote_rst);
  // R3
  mask_block_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(remote_rst) |-> !$past(mask_s));
  // R9
  clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_enter) |-> $past(clr_we && clr_sel[0]));
endmodule

bind remote_core_boot_ctl rcb_chk #(.BOOT_W(BOOT_W), .MIN_HOLD(MIN_HOLD)) u_chk (
  .clk(clk), .rst(rst), .remote_rst(remote_rst), .remote_boot(remote_boot),
  .pend_enter(pend_enter), .pend_leave(pend_leave), .mask_s(mask_sync),
  .hold_q(hold_q), .clr_we(clr_we), .clr_sel(clr_sel)
);

// File: tb/tb_remote_core_boot_ctl.sv
module tb_remote_core_boot_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0, cfg_hr = 1'b0, cfg_hold = 1'b0;
  logic [1:0] cfg_boot = 2'd0;
  logic       clr_we = 1'b0;
  logic [1:0] clr_sel = 2'd0;
  logic       remote_mask = 1'b0;
  logic       remote_rst, pend_enter, pend_leave, irq_enter, irq_leave;
  logic [1:0] remote_boot;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    logic [6:0] vec;
    string      req;
  } exp_t;
  exp_t sb[$];

  remote_core_boot_ctl dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_hr(cfg_hr), .cfg_hold(cfg_hold),
    .cfg_boot(cfg_boot), .clr_we(clr_we), .clr_sel(clr_sel),
    .remote_mask(remote_mask), .remote_rst(remote_rst), .remote_boot(remote_boot),
    .pend_enter(pend_enter), .pend_leave(pend_leave),
    .irq_enter(irq_enter), .irq_leave(irq_leave)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [6:0] mk(logic r, logic [1:0] b, logic pe, logic pl);
    return {r, b, pe, pl, pe, pl}; // R10: interrupt lines mirror flags
  endfunction

  task automatic expect_at(int at, logic [6:0] v, string req);
    exp_t e;
    e.at = at; e.vec = v; e.req = req;
    sb.push_back(e);
  endtask

  task automatic wait_to(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic cfg_at(int n, logic hr, logic hold, logic [1:0] boot);
    wait_to(n);
    cfg_we = 1'b1; cfg_hr = hr; cfg_hold = hold; cfg_boot = boot;
    wait_to(n + 1);
    cfg_we = 1'b0;
  endtask

  task automatic clr_at(int n, logic [1:0] sel);
    wait_to(n);
    clr_we = 1'b1; clr_sel = sel;
    wait_to(n + 1);
    clr_we = 1'b0; clr_sel = 2'd0;
  endtask

  // Monitor: pops expectations due this cycle and compares
  always @(negedge clk) begin
    logic [6:0] got;
    got = {remote_rst, remote_boot, pend_enter, pend_leave, irq_enter, irq_leave};
    for (int i = 0; i < sb.size(); ) begin
      if (sb[i].at == cyc) begin
        checks++;
        if (got !== sb[i].vec) begin
          errors++;
          $display("FAIL %s cycle %0d got %b expected %b", sb[i].req, cyc, got, sb[i].vec);
        end
        sb.delete(i);
      end else begin
        i++;
      end
    end
  end

  initial begin
    expect_at(2, mk(0, 0, 0, 0), "R1 in reset");
    expect_at(3, mk(0, 0, 0, 0), "R1 after reset");
    wait_to(2);
    rst = 1'b0;

    // R2 R4 R6 R7 R8 R10: request then immediate clear
    expect_at(11, mk(0, 0, 0, 0), "R2 not early");
    expect_at(12, mk(1, 0, 1, 0), "R2 R7 R10 reset entered");
    expect_at(15, mk(1, 0, 1, 0), "R4 minimum hold");
    expect_at(16, mk(0, 2, 1, 1), "R6 R8 release with mode");
    cfg_at(10, 1'b1, 1'b0, 2'd2);
    cfg_at(11, 1'b0, 1'b0, 2'd2);

    // R9 clears
    expect_at(21, mk(0, 2, 0, 1), "R9 clear entered flag");
    expect_at(23, mk(0, 2, 0, 1), "R9 zero write no effect");
    expect_at(25, mk(0, 2, 0, 0), "R9 clear left flag");
    clr_at(20, 2'b01);
    clr_at(22, 2'b00);
    clr_at(24, 2'b10);

    // R5 hold
    expect_at(40, mk(1, 2, 1, 0), "R5 held, mode unchanged");
    expect_at(46, mk(1, 2, 1, 0), "R5 still held at hold clear write");
    expect_at(47, mk(0, 1, 1, 1), "R6 boot held core");
    cfg_at(30, 1'b1, 1'b1, 2'd3);
    cfg_at(31, 1'b0, 1'b1, 2'd3);
    cfg_at(45, 1'b0, 1'b0, 2'd1);

    // R9 set beats clear on same edge
    expect_at(51, mk(0, 1, 0, 0), "R9 clear both");
    expect_at(57, mk(1, 1, 1, 0), "R9 set wins over clear");
    expect_at(61, mk(0, 0, 1, 1), "R6 R8 release mode 0");
    clr_at(50, 2'b11);
    cfg_at(55, 1'b1, 1'b0, 2'd0);
    clr_at(56, 2'b01);
    cfg_at(58, 1'b0, 1'b0, 2'd0);

    // R3 mask
    expect_at(66, mk(0, 0, 0, 0), "R9 clear before mask test");
    expect_at(80, mk(0, 0, 0, 0), "R3 masked request blocked");
    expect_at(90, mk(0, 0, 0, 0), "R3 still blocked");
    expect_at(97, mk(0, 0, 0, 0), "R3 sync delay");
    expect_at(98, mk(1, 0, 1, 0), "R3 proceeds after unmask");
    expect_at(102, mk(0, 3, 1, 1), "R6 release after unmask");
    clr_at(65, 2'b11);
    wait_to(70);
    remote_mask = 1'b1;
    cfg_at(75, 1'b1, 1'b0, 2'd3);
    wait_to(95);
    remote_mask = 1'b0;
    cfg_at(100, 1'b0, 1'b0, 2'd3);

    wait_to(110);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R1 scoreboard left %0d unchecked got %0d expected 0", sb.size(), sb.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule